// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block sits between a CPU bus and an embedded flash array and turns bus writes into flash operations. Software writes a command code on the low byte of a 16-bit word at an even address. Some commands act at once. These switch what reads return or clear the error bits. Other commands open a two-write sequence. That sequence is either a data word for a program, or a D0h confirm for erase and lock operations. It is checked before anything is sent to the flash backend.

Reads are steered by a persistent read mode. In array mode a read returns the array word at the bus address. In status mode it returns the status byte. The status byte carries four flags:
- a ready flag;
- the last lock-bit read result;
- an erase or sequence error;
- a program error.

Accepted operations go out on a request/acknowledge port. The block then waits for a completion pulse. Until that pulse arrives it refuses further command writes and reports not-ready.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in array mode (`rd_array` = 1), no request is pending, and the status byte reads 80h.
- R2: Writing a word whose low byte is FFh enters array mode; bits 15..8 of any command write are ignored. In array mode every read returns `arr_rdata`, with `arr_addr` following `bus_addr`. The mode holds until another command is written.
- R3: Writing 70h enters status mode. Reads then return {8'h00, status}, where status bit 7 = ready, bit 6 = last lock-bit read result, bit 5 = erase/sequence error, bit 4 = program error, and bits 3..0 = 0.
- R4: Writing 50h clears status bits 5 and 4 and leaves the read mode and bit 6 unchanged.
- R5: Writing 40h at address A and then a data word D at the same address A issues a request with op 0, `be_addr` = A and `be_data` = D.
- R6: A 20h write, a 77h write or a 71h write at block address B, each followed by D0h at the same B, issues op 1, op 3 or op 4 respectively. When op 4 completes without failure, status bit 6 takes the value of `be_lock`.
- R7: Writing A7h followed by D0h at any even address issues op 2 with `be_addr` equal to the second-cycle address.
- R8: Any of the following sets status bits 5 and 4, issues no request, and leaves the block idle in status mode:
  - an unknown first-cycle code;
  - a second cycle that is not D0h for an erase or lock command;
  - a second-cycle address that differs from the first for any two-cycle command other than erase-all.
- R9: A read or write at an odd address while not busy sets status bits 5 and 4, aborts any open sequence, selects status mode and issues no request.
- R10: `be_req` and its op, address and data stay stable until `be_ack`; the block then waits for `be_done`. From the request until done, status bit 7 reads 0 and command writes are ignored.
- R11: On `be_done` with `be_fail`, ops 1 and 2 (erase) set status bit 5 and ops 0, 3 and 4 set status bit 4. After done, status bit 7 returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Bus byte address |
| bus_wdata | input | 16 | Bus write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, array word or status byte |
| rd_array | output | 1 | Mode flag, 1 in array mode |
| arr_addr | output | AW | Array read address |
| arr_rdata | input | 16 | Array read data |
| be_req | output | 1 | Backend request, held until acknowledged |
| be_op | output | 3 | Operation: 0 program, 1 block erase, 2 erase all, 3 lock program, 4 lock read |
| be_addr | output | AW | Operation address |
| be_data | output | 16 | Program data |
| be_ack | input | 1 | Backend accepted the request |
| be_done | input | 1 | Backend finished, one-cycle pulse |
| be_fail | input | 1 | Failure flag, valid with be_done |
| be_lock | input | 1 | Lock-bit value, valid with be_done |

## Verification
The assertions assume the following about the backend:
- it raises `be_ack` only while `be_req` is high;
- it pulses `be_done` only after acknowledging;
- it never completes in the same cycle it acknowledges.

They also assume the bus issues at most one write strobe per cycle. The bench backend model waits for a request, gives a single acknowledge pulse, and then holds off done for several cycles, during which it probes the status and attempts a command. Bus accesses are driven one per task call and are always separated by idle cycles.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_REQ, ST_BUSY} seq_st_t;
    typedef enum logic [2:0] {
        OP_PROG = 3'd0, OP_BERASE = 3'd1, OP_EALL = 3'd2,
        OP_LKPROG = 3'd3, OP_LKRD = 3'd4
    } be_op_t;
    typedef enum logic [2:0] {K_ARRAY, K_STATUS, K_CLEAR, K_TWO, K_BAD} cmd_kind_t;
    localparam int CODE_W = 8;
    localparam logic [CODE_W-1:0] CONFIRM = 8'hD0;
endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
    import fcs_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output cmd_kind_t         kind,
    output be_op_t            op
);
    always_comb begin
        kind = K_TWO;
        op   = OP_PROG;
        case (code)
            8'hFF: kind = K_ARRAY;
            8'h70: kind = K_STATUS;
            8'h50: kind = K_CLEAR;
            8'h40: op   = OP_PROG;
            8'h20: op   = OP_BERASE;
            8'hA7: op   = OP_EALL;
            8'h77: op   = OP_LKPROG;
            8'h71: op   = OP_LKRD;
            default: kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/fcs_rdmux.sv
module fcs_rdmux #(
    parameter int DW = 16
) (
    input  logic          sel_array,
    input  logic [DW-1:0] arr_rdata,
    input  logic [7:0]    status,
    output logic [DW-1:0] rdata
);
    localparam int PAD = DW - 8;
    always_comb begin
        if (sel_array) rdata = arr_rdata;
        else           rdata = {{PAD{1'b0}}, status};
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    input  logic          bus_re,
    output logic [DW-1:0] bus_rdata,
    output logic          rd_array,
    output logic [AW-1:0] arr_addr,
    input  logic [DW-1:0] arr_rdata,
    output logic          be_req,
    output logic [2:0]    be_op,
    output logic [AW-1:0] be_addr,
    output logic [DW-1:0] be_data,
    input  logic          be_ack,
    input  logic          be_done,
    input  logic          be_fail,
    input  logic          be_lock
);
    typedef struct packed {
        seq_st_t       state;
        logic          mode_arr;
        be_op_t        op;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          sr6;
        logic          sr5;
        logic          sr4;
    } regs_t;

    regs_t     d, q;
    cmd_kind_t dec_kind;
    be_op_t    dec_op;
    logic [7:0] status_w;
    logic      busy_w, wr_ok, odd_acc, same_addr, go, err;

    fcs_decode u_decode (
        .code (bus_wdata[CODE_W-1:0]),
        .kind (dec_kind),
        .op   (dec_op)
    );

    assign busy_w   = (q.state == ST_REQ) || (q.state == ST_BUSY);
    assign status_w = {~busy_w, q.sr6, q.sr5, q.sr4, 4'b0000};

    always_comb begin
        d         = q;
        go        = 1'b0;
        err       = 1'b0;
        wr_ok     = bus_we && !bus_addr[0];
        odd_acc   = (bus_we || bus_re) && bus_addr[0];
        same_addr = (bus_addr == q.addr);
        case (q.state)
            ST_IDLE: if (wr_ok) begin
                case (dec_kind)
                    K_ARRAY:  d.mode_arr = 1'b1;
                    K_STATUS: d.mode_arr = 1'b0;
                    K_CLEAR: begin
                        d.sr5 = 1'b0;
                        d.sr4 = 1'b0;
                    end
                    K_TWO: begin
                        d.state = ST_ARM;
                        d.op    = dec_op;
                        d.addr  = bus_addr;
                    end
                    default: err = 1'b1;
                endcase
            end
            ST_ARM: if (wr_ok) begin
                if (q.op == OP_PROG) begin
                    if (same_addr) begin
                        d.data = bus_wdata;
                        go     = 1'b1;
                    end else begin
                        err = 1'b1;
                    end
                end else if (bus_wdata[CODE_W-1:0] != CONFIRM ||
                             (!same_addr && q.op != OP_EALL)) begin
                    err = 1'b1;
                end else begin
                    d.addr = bus_addr;
                    go     = 1'b1;
                end
            end
            ST_REQ: if (be_ack) d.state = ST_BUSY;
            default: if (be_done) begin
                d.state = ST_IDLE;
                if (be_fail) begin
                    if (q.op == OP_BERASE || q.op == OP_EALL) d.sr5 = 1'b1;
                    else                                      d.sr4 = 1'b1;
                end else if (q.op == OP_LKRD) begin
                    d.sr6 = be_lock;
                end
            end
        endcase
        if (odd_acc && !busy_w) err = 1'b1;
        if (go) begin
            d.state    = ST_REQ;
            d.mode_arr = 1'b0;
        end
        if (err) begin
            d.state    = ST_IDLE;
            d.mode_arr = 1'b0;
            d.sr5      = 1'b1;
            d.sr4      = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= ST_IDLE;
            q.mode_arr <= 1'b1;
            q.op       <= OP_PROG;
        end else begin
            q <= d;
        end
    end

    fcs_rdmux #(.DW(DW)) u_rdmux (
        .sel_array (q.mode_arr),
        .arr_rdata (arr_rdata),
        .status    (status_w),
        .rdata     (bus_rdata)
    );

    assign rd_array = q.mode_arr;
    assign arr_addr = bus_addr;
    assign be_req   = (q.state == ST_REQ);
    assign be_op    = q.op;
    assign be_addr  = q.addr;
    assign be_data  = q.data;

    // R10: request and its payload held until acknowledged
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && !be_ack) |=> (be_req && $stable(be_op) && $stable(be_addr) && $stable(be_data)));

    // R10: while a request is outstanding the read path reports not-ready
    assert_req_notready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |-> (!rd_array && !bus_rdata[7]));

    // R9: an odd write never launches a request
    assert_odd_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[0] && !be_req) |=> !be_req);

    // R4: an accepted clear leaves both error bits low
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && bus_we && !bus_addr[0] && bus_wdata[7:0] == 8'h50)
        |=> (status_w[5:4] == 2'b00));

    // R11: completion restores ready
    assert_done_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_BUSY && be_done) |=> status_w[7]);
endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
    localparam int AW = 20;
    localparam time CYC = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic          bus_we = 1'b0, bus_re = 1'b0;
    logic [15:0]   bus_rdata, arr_rdata, be_data;
    logic          rd_array, be_req;
    logic [AW-1:0] arr_addr, be_addr;
    logic [2:0]    be_op;
    logic          be_ack = 1'b0, be_done = 1'b0, be_fail = 1'b0, be_lock = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CYC/2) clk = ~clk;

    function automatic logic [15:0] amodel(input logic [AW-1:0] a);
        return a[15:0] ^ 16'hA5A5;
    endfunction
    assign arr_rdata = amodel(arr_addr);

    flash_cmd_seq #(.AW(AW), .DW(16)) u_flash_cmd_seq (
        .clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .bus_re, .bus_rdata,
        .rd_array, .arr_addr, .arr_rdata, .be_req, .be_op, .be_addr, .be_data,
        .be_ack, .be_done, .be_fail, .be_lock
    );

    typedef struct packed {
        logic [1:0]    k;     // 0 write, 1 read status/expected, 2 read array model
        logic [AW-1:0] a;
        logic [15:0]   d;
        logic [3:0]    tag;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 20'h00100, 16'h0000, 4'd1},  // R1 array mode after reset
        '{2'd0, 20'h00000, 16'h0070, 4'd3},
        '{2'd1, 20'h00000, 16'h0080, 4'd3},  // R3 status byte
        '{2'd0, 20'h00000, 16'hAAFF, 4'd2},
        '{2'd2, 20'h00200, 16'h0000, 4'd2},  // R2 high byte ignored
        '{2'd2, 20'h0ABCE, 16'h0000, 4'd2},  // R2 mode persists
        '{2'd0, 20'h00000, 16'h0070, 4'd3},
        '{2'd0, 20'h00010, 16'h0020, 4'd8},
        '{2'd0, 20'h00010, 16'h00AA, 4'd8},
        '{2'd1, 20'h00000, 16'h00B0, 4'd8},  // R8 bad confirm
        '{2'd0, 20'h00000, 16'h0050, 4'd4},
        '{2'd1, 20'h00000, 16'h0080, 4'd4},  // R4 clear
        '{2'd0, 20'h00001, 16'h00FF, 4'd9},
        '{2'd1, 20'h00000, 16'h00B0, 4'd9},  // R9 odd write flagged, FF ignored
        '{2'd0, 20'h00000, 16'h1250, 4'd4},
        '{2'd0, 20'h00020, 16'h0040, 4'd8},
        '{2'd0, 20'h00022, 16'h1234, 4'd8},
        '{2'd1, 20'h00000, 16'h00B0, 4'd8},  // R8 program address mismatch
        '{2'd0, 20'h00000, 16'h0050, 4'd4},
        '{2'd0, 20'h00000, 16'h0033, 4'd8},
        '{2'd1, 20'h00000, 16'h00B0, 4'd8},  // R8 unknown code
        '{2'd0, 20'h00000, 16'h0050, 4'd4},
        '{2'd0, 20'h00030, 16'h0077, 4'd8},
        '{2'd0, 20'h00032, 16'h00D0, 4'd8},
        '{2'd1, 20'h00000, 16'h00B0, 4'd8},  // R8 lock address mismatch
        '{2'd0, 20'h00000, 16'h0050, 4'd4},
        '{2'd0, 20'h00000, 16'h00FF, 4'd2},
        '{2'd2, 20'h00005, 16'h0000, 4'd9},  // R9 odd read still returns array word
        '{2'd1, 20'h00004, 16'h00B0, 4'd9},  // R9 odd read flagged, status mode
        '{2'd0, 20'h00000, 16'h0050, 4'd4}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] dt);
        @(negedge clk);
        bus_addr = a; bus_wdata = dt; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 check(req, 32'(bus_rdata), 32'(exp));
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic serve(input logic [2:0] eop, input logic [AW-1:0] eaddr,
                         input logic chkdata, input logic [15:0] edata,
                         input logic fail, input logic lk,
                         input logic [7:0] busy_sr, input logic [7:0] end_sr,
                         input string req);
        int wait_n = 0;
        while (!be_req && wait_n < 20) begin
            @(negedge clk);
            wait_n++;
        end
        check({req, " request"}, 32'(be_req), 32'd1);
        check({req, " op"}, 32'(be_op), 32'(eop));
        check({req, " addr"}, 32'(be_addr), 32'(eaddr));
        if (chkdata) check({req, " data"}, 32'(be_data), 32'(edata));
        be_ack = 1'b1;
        @(negedge clk);
        be_ack = 1'b0;
        rd(20'h00000, {8'h00, busy_sr}, "R10 busy status");
        wr(20'h00000, 16'h00FF);
        check("R10 write ignored while busy", 32'(rd_array), 32'd0);
        rd(20'h00000, {8'h00, busy_sr}, "R10 still busy");
        @(negedge clk);
        be_done = 1'b1; be_fail = fail; be_lock = lk;
        @(negedge clk);
        be_done = 1'b0; be_fail = 1'b0; be_lock = 1'b0;
        rd(20'h00000, {8'h00, end_sr}, {req, " final status"});
    endtask

    initial begin
        #(CYC * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset mode flag", 32'(rd_array), 32'd1);
        check("R1 no request after reset", 32'(be_req), 32'd0);

        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R%0d vector %0d", VECS[i].tag, i);
            case (VECS[i].k)
                2'd0: wr(VECS[i].a, VECS[i].d);
                2'd1: rd(VECS[i].a, VECS[i].d, tg);
                default: rd(VECS[i].a, amodel(VECS[i].a), tg);
            endcase
        end

        // R5 program
        wr(20'h00100, 16'h0040);
        wr(20'h00100, 16'hBEEF);
        serve(3'd0, 20'h00100, 1'b1, 16'hBEEF, 1'b0, 1'b0, 8'h00, 8'h80, "R5 program");
        // R6 block erase with failure (R11 sets bit 5)
        wr(20'h0FFFE, 16'h0020);
        wr(20'h0FFFE, 16'h00D0);
        serve(3'd1, 20'h0FFFE, 1'b0, 16'h0, 1'b1, 1'b0, 8'h00, 8'hA0, "R11 erase fail");
        wr(20'h00000, 16'h0050);
        // R7 erase all at a different address, high byte of confirm ignored
        wr(20'h00000, 16'h00A7);
        wr(20'h00444, 16'h33D0);
        serve(3'd2, 20'h00444, 1'b0, 16'h0, 1'b0, 1'b0, 8'h00, 8'h80, "R7 erase all");
        // R6 lock read returns lock bit into bit 6
        wr(20'h1FFFE, 16'h0071);
        wr(20'h1FFFE, 16'h00D0);
        serve(3'd4, 20'h1FFFE, 1'b0, 16'h0, 1'b0, 1'b1, 8'h00, 8'hC0, "R6 lock read");
        // R6 lock program with failure sets bit 4 (R11)
        wr(20'h0FFFE, 16'h0077);
        wr(20'h0FFFE, 16'h00D0);
        serve(3'd3, 20'h0FFFE, 1'b0, 16'h0, 1'b1, 1'b0, 8'h40, 8'hD0, "R11 lock program fail");
        // R4 clear keeps bit 6 and mode
        wr(20'h00000, 16'h0050);
        rd(20'h00000, 16'h00C0, "R4 clear keeps lock result");
        check("R4 clear keeps status mode", 32'(rd_array), 32'd0);

        // R1 reset again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mode after reset", 32'(rd_array), 32'd1);
        wr(20'h00000, 16'h0070);
        rd(20'h00000, 16'h0080, "R1 status after reset");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule